// File: doc/BRIEF.md
# DRAM Maintenance Command Sequencer

This block runs the housekeeping side of a DDR3-style command path. It tracks how many refreshes the memory is owed and offers each one to the main command scheduler. It also handles ZQ calibration requests and a self-refresh request, which can be entered and left again. Each maintenance command is offered with a request/grant handshake. The scheduler may hold off its grant, which postpones refreshes; an owed-refresh count and an urgency flag let it see how far behind it has fallen.

All timing is given in clock cycles on configuration inputs. A caller that starts from nanoseconds or microseconds rounds up when converting. The configuration covers:
- the average refresh interval, which is halved internally while the high-temperature input is set;
- the refresh cycle time;
- the self-refresh exit delay for commands that do not need the DLL;
- the DLL relock delay;
- the minimum self-refresh residency;
- the long and short calibration times.

While a command's timing window is open, `busy_o` is high so that read and write traffic is held back. `dll_rdy_o` separately gates commands that need a locked DLL after a self-refresh exit.

Top module: `dram_maint_seq`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are: `cmd_o` = NOP, `busy_o`, `cmd_req_o`, `in_sr_o` and `urgent_o` low, `pend_o` = 0 and `dll_rdy_o` high.
- R2: When not in self-refresh, one owed refresh is added every L clock edges, where L = `cfg_refi_i`, or `cfg_refi_i >> 1` while `hot_i` is high. A value of 0 counts as 1. From reset with no grants, `pend_o` equals floor(edges / L).
- R3: `pend_o` counts owed refreshes, saturating at 31. `urgent_o` is high exactly when `pend_o` exceeds 8.
- R4: A command appears on `cmd_o` in the cycle after a clock edge at which both `cmd_req_o` and `cmd_gnt_i` are high. At all other times `cmd_o` shows NOP. `cmd_o` is always one-hot, with bit 0 = NOP, 1 = REF, 2 = SRE, 3 = SRX, 4 = ZQCL, 5 = ZQCS.
- R5: When more than one command is wanted, REF (owed count above zero) wins over ZQ calibration, and ZQ calibration wins over self-refresh entry.
- R6: A REF, ZQCL, ZQCS or SRX holds `busy_o` high from its `cmd_o` cycle for exactly `cfg_rfc_i`, `cfg_zqcl_i`, `cfg_zqcs_i` or `cfg_xs_i` cycles (a 0 counts as 1). No new request is raised while that window is open.
- R7: Refresh credit keeps accruing during open windows and while grants are withheld. No owed refresh is ever dropped: once `pend_o` returns to 0, the number of REF commands issued equals the number of credits accrued.
- R8: SRE is offered only when `pend_o` is 0, no window is open and no calibration is pending. While in self-refresh, `in_sr_o` and `busy_o` are high and no refresh credit accrues.
- R9: SRX is offered only once `sr_req_i` is low and at least `cfg_srmin_i` cycles have passed in self-refresh. With the grant always high, SRX appears on `cmd_o` exactly `cfg_srmin_i`+1 cycles after SRE.
- R10: `dll_rdy_o` is low throughout self-refresh and for max(`cfg_dllk_i`,1) cycles starting at the SRX `cmd_o` cycle.
- R11: A one-cycle `zq_req_i` pulse is held until served. It is served as ZQCL if `zq_long_i` was high with the pulse, and as ZQCS otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_refi_i | input | CW | Average refresh interval, cycles |
| cfg_rfc_i | input | CW | Refresh cycle time, cycles |
| cfg_xs_i | input | CW | Self-refresh exit delay for commands not needing the DLL |
| cfg_dllk_i | input | CW | DLL relock delay after self-refresh exit |
| cfg_srmin_i | input | CW | Minimum cycles in self-refresh before exit |
| cfg_zqcl_i | input | CW | Long calibration time |
| cfg_zqcs_i | input | CW | Short calibration time |
| hot_i | input | 1 | High temperature range: doubles the refresh rate |
| sr_req_i | input | 1 | Level request to be in self-refresh |
| zq_req_i | input | 1 | Calibration request pulse |
| zq_long_i | input | 1 | Selects long calibration for the request pulse |
| cmd_gnt_i | input | 1 | Grant from the main scheduler |
| cmd_req_o | output | 1 | A maintenance command wants the command slot |
| cmd_o | output | 6 | One-hot command issued this cycle |
| busy_o | output | 1 | Normal traffic must be held |
| in_sr_o | output | 1 | Memory is in self-refresh |
| dll_rdy_o | output | 1 | Commands needing a locked DLL are allowed |
| pend_o | output | PW | Owed refresh count |
| urgent_o | output | 1 | More than 8 refreshes owed |

## Verification
The hardest situations to reach are a deep postponement backlog and the overlap of owed refreshes with pending calibration and a self-refresh request. With ordinary grant rates, the credit never climbs past one. The stimulus therefore withholds grants for long stretches: a directed run keeps the grant low for nine intervals to reach the urgency threshold and then drains the backlog. The random phases switch between grant-starved and grant-rich modes while calibration pulses and self-refresh requests arrive. A cycle model in the bench follows every output through all of this.

// File: rtl/dram_maint_pkg.sv
package dram_maint_pkg;
    localparam int CMD_W = 6;
    localparam int B_NOP = 0;
    localparam int B_REF = 1;
    localparam int B_SRE = 2;
    localparam int B_SRX = 3;
    localparam int B_ZQL = 4;
    localparam int B_ZQS = 5;
    localparam logic [CMD_W-1:0] CMD_IDLE = CMD_W'(1);

    typedef enum logic {ST_RUN = 1'b0, ST_SR = 1'b1} mstate_e;
endpackage

// File: rtl/dram_maint_credit.sv
module dram_maint_credit #(
    parameter int CW = 16,
    parameter int PW = 5,
    parameter int POST_MAX = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          hot_i,
    input  logic [CW-1:0] refi_i,
    input  logic          take_i,
    output logic [PW-1:0] pend_o,
    output logic          urgent_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] pend;
    } cred_t;

    cred_t q, d;
    logic [CW-1:0] lim;
    logic          tick;

    always_comb begin
        lim = hot_i ? (refi_i >> 1) : refi_i;
        if (lim == '0) lim = CW'(1);
        tick = run_i && (q.cnt >= lim - CW'(1));
        d = q;
        if (!run_i)    d.cnt = '0;
        else if (tick) d.cnt = '0;
        else           d.cnt = q.cnt + CW'(1);
        if (tick && !take_i) begin
            if (q.pend != '1) d.pend = q.pend + PW'(1);
        end else if (!tick && take_i) begin
            if (q.pend != '0) d.pend = q.pend - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_o   = q.pend;
    assign urgent_o = (q.pend > PW'(POST_MAX));
endmodule

// File: rtl/dram_maint_win.sv
module dram_maint_win #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          active_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)             cnt_d = (len_i == '0) ? CW'(1) : len_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
        else                    cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active_o = (cnt_q != '0);
endmodule

// File: rtl/dram_maint_seq.sv
module dram_maint_seq
    import dram_maint_pkg::*;
#(
    parameter int CW = 16,
    parameter int POST_MAX = 8,
    localparam int PW = $clog2(POST_MAX + 2) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cfg_refi_i,
    input  logic [CW-1:0]    cfg_rfc_i,
    input  logic [CW-1:0]    cfg_xs_i,
    input  logic [CW-1:0]    cfg_dllk_i,
    input  logic [CW-1:0]    cfg_srmin_i,
    input  logic [CW-1:0]    cfg_zqcl_i,
    input  logic [CW-1:0]    cfg_zqcs_i,
    input  logic             hot_i,
    input  logic             sr_req_i,
    input  logic             zq_req_i,
    input  logic             zq_long_i,
    input  logic             cmd_gnt_i,
    output logic             cmd_req_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic             busy_o,
    output logic             in_sr_o,
    output logic             dll_rdy_o,
    output logic [PW-1:0]    pend_o,
    output logic             urgent_o
);
    typedef struct packed {
        mstate_e          st;
        logic [CW-1:0]    sr_cnt;
        logic             zq_pend;
        logic             zq_long;
        logic [CMD_W-1:0] cmd;
    } seq_t;

    seq_t q, d;
    logic          win_act, dll_act;
    logic [PW-1:0] pend;
    logic          idle, want_ref, want_zq, want_sre, want_srx, issue;
    logic          win_load, dll_load;
    logic [CW-1:0] win_len;

    dram_maint_credit #(.CW(CW), .PW(PW), .POST_MAX(POST_MAX)) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (q.st == ST_RUN),
        .hot_i    (hot_i),
        .refi_i   (cfg_refi_i),
        .take_i   (issue && want_ref),
        .pend_o   (pend),
        .urgent_o (urgent_o)
    );

    dram_maint_win #(.CW(CW)) u_busy_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (win_load),
        .len_i    (win_len),
        .active_o (win_act)
    );

    dram_maint_win #(.CW(CW)) u_dll_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (dll_load),
        .len_i    (cfg_dllk_i),
        .active_o (dll_act)
    );

    always_comb begin
        idle     = (q.st == ST_RUN) && !win_act;
        want_ref = idle && (pend != '0);
        want_zq  = idle && (pend == '0) && q.zq_pend;
        want_sre = idle && (pend == '0) && !q.zq_pend && sr_req_i;
        want_srx = (q.st == ST_SR) && !sr_req_i && (q.sr_cnt >= cfg_srmin_i);
        cmd_req_o = want_ref || want_zq || want_sre || want_srx;
        issue    = cmd_req_o && cmd_gnt_i;

        win_load = issue && !want_sre;
        if (want_ref)     win_len = cfg_rfc_i;
        else if (want_zq) win_len = q.zq_long ? cfg_zqcl_i : cfg_zqcs_i;
        else              win_len = cfg_xs_i;
        dll_load = issue && want_srx;

        d = q;
        d.cmd = CMD_IDLE;
        if (issue) begin
            d.cmd = '0;
            if (want_ref)      d.cmd[B_REF] = 1'b1;
            else if (want_zq)  d.cmd[q.zq_long ? B_ZQL : B_ZQS] = 1'b1;
            else if (want_sre) d.cmd[B_SRE] = 1'b1;
            else               d.cmd[B_SRX] = 1'b1;
        end

        if (issue && want_zq) d.zq_pend = 1'b0;
        if (zq_req_i) begin
            d.zq_pend = 1'b1;
            d.zq_long = zq_long_i;
        end

        if ((q.st == ST_SR) && (q.sr_cnt != '1)) d.sr_cnt = q.sr_cnt + CW'(1);
        if (issue && want_sre) begin
            d.st     = ST_SR;
            d.sr_cnt = '0;
        end
        if (issue && want_srx) d.st = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_RUN, sr_cnt: '0, zq_pend: 1'b0, zq_long: 1'b0, cmd: CMD_IDLE};
        else        q <= d;
    end

    assign cmd_o     = q.cmd;
    assign in_sr_o   = (q.st == ST_SR);
    assign busy_o    = win_act || (q.st == ST_SR);
    assign dll_rdy_o = !dll_act && (q.st == ST_RUN);
    assign pend_o    = pend;
endmodule

// File: rtl/dram_maint_chk.sv
module dram_maint_chk #(
    parameter int POST_MAX = 8,
    localparam int PW = $clog2(POST_MAX + 2) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_req_o,
    input logic          cmd_gnt_i,
    input logic [5:0]    cmd_o,
    input logic          busy_o,
    input logic          in_sr_o,
    input logic          dll_rdy_o,
    input logic [PW-1:0] pend_o
);
    // R4
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_o) == 1);

    // R4
    cmd_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_o[0] |-> $past(cmd_req_o && cmd_gnt_i));

    // R6
    busy_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_o[0] |-> busy_o);

    // R6
    no_req_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !in_sr_o) |-> !cmd_req_o);

    // R8
    sre_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o[2] |-> ($past(pend_o) == '0 && !$past(busy_o)));

    // R8
    sr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_sr_o |-> busy_o);

    // R10
    dll_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o[3] || in_sr_o) |-> !dll_rdy_o);

    // R5
    ref_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o[1] |-> $past(pend_o) != '0);
endmodule

bind dram_maint_seq dram_maint_chk #(.POST_MAX(POST_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_req_o (cmd_req_o),
    .cmd_gnt_i (cmd_gnt_i),
    .cmd_o     (cmd_o),
    .busy_o    (busy_o),
    .in_sr_o   (in_sr_o),
    .dll_rdy_o (dll_rdy_o),
    .pend_o    (pend_o)
);

// File: tb/dram_maint_seq_bench.sv
module dram_maint_seq_bench;
    localparam int CW = 16;
    localparam int PW = $clog2(8 + 2) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] refi = 30, rfc = 5, xs = 7, dllk = 12, srmin = 6, zqcl = 20, zqcs = 4;
    logic hot = 0, sr_req = 0, zq_req = 0, zq_long = 0, gnt = 0;
    logic cmd_req, busy, in_sr, dll_rdy, urgent;
    logic [5:0] cmd;
    logic [PW-1:0] pend;

    int n_chk = 0, n_fail = 0, cyc_n = 0, nedge = 0;
    bit done = 0;

    // bench reference state
    int m_sr, m_win, m_dll, m_cnt, m_pend, m_zqp, m_zql, m_srcnt, m_cmd;

    always #5 clk = ~clk;

    dram_maint_seq #(.CW(CW), .POST_MAX(8)) u_dram_maint_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_refi_i(refi), .cfg_rfc_i(rfc), .cfg_xs_i(xs), .cfg_dllk_i(dllk),
        .cfg_srmin_i(srmin), .cfg_zqcl_i(zqcl), .cfg_zqcs_i(zqcs),
        .hot_i(hot), .sr_req_i(sr_req), .zq_req_i(zq_req), .zq_long_i(zq_long),
        .cmd_gnt_i(gnt), .cmd_req_o(cmd_req), .cmd_o(cmd), .busy_o(busy),
        .in_sr_o(in_sr), .dll_rdy_o(dll_rdy), .pend_o(pend), .urgent_o(urgent)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc_n);
        end
    endtask

    function automatic int at_least1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic model_clear();
        m_sr = 0; m_win = 0; m_dll = 0; m_cnt = 0; m_pend = 0;
        m_zqp = 0; m_zql = 0; m_srcnt = 0; m_cmd = 1; nedge = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; gnt = 0; sr_req = 0; zq_req = 0; zq_long = 0; hot = 0;
        repeat (2) @(negedge clk);
        check("R1 cmd_o in reset", int'(cmd), 1);
        check("R1 busy_o in reset", int'(busy), 0);
        check("R1 cmd_req_o in reset", int'(cmd_req), 0);
        check("R1 pend_o in reset", int'(pend), 0);
        check("R1 dll_rdy_o in reset", int'(dll_rdy), 1);
        check("R1 in_sr_o in reset", int'(in_sr), 0);
        check("R1 urgent_o in reset", int'(urgent), 0);
        @(posedge clk); #2;
        rst_n = 1;
        model_clear();
    endtask

    // one clock: drive at negedge, compare against bench model, advance model,
    // return just after the edge so outputs show the new state
    task automatic step(input logic g, input logic s, input logic z, input logic zl, input logic h);
        int lim, tick, idle, wref, wzq, wsre, wsrx, req, iss;
        @(negedge clk);
        gnt = g; sr_req = s; zq_req = z; zq_long = zl; hot = h;
        #1;
        idle = (!m_sr && m_win == 0) ? 1 : 0;
        wref = (idle && m_pend != 0) ? 1 : 0;
        wzq  = (idle && m_pend == 0 && m_zqp) ? 1 : 0;
        wsre = (idle && m_pend == 0 && !m_zqp && s) ? 1 : 0;
        wsrx = (m_sr && !s && m_srcnt >= int'(srmin)) ? 1 : 0;
        req  = wref | wzq | wsre | wsrx;
        check("R5 cmd_req_o", int'(cmd_req), req);
        check("R4 cmd_o", int'(cmd), m_cmd);
        check("R6 busy_o", int'(busy), (m_win != 0 || m_sr) ? 1 : 0);
        check("R8 in_sr_o", int'(in_sr), m_sr);
        check("R10 dll_rdy_o", int'(dll_rdy), (m_dll == 0 && !m_sr) ? 1 : 0);
        check("R2 pend_o", int'(pend), m_pend);
        check("R3 urgent_o", int'(urgent), (m_pend > 8) ? 1 : 0);
        iss = req & int'(g);
        lim = h ? int'(refi) / 2 : int'(refi);
        lim = at_least1(lim);
        tick = (!m_sr && m_cnt >= lim - 1) ? 1 : 0;
        m_cnt = (!m_sr && !tick) ? m_cnt + 1 : 0;
        if (tick && !(iss && wref)) begin
            if (m_pend < 31) m_pend++;
        end else if (!tick && iss && wref) begin
            if (m_pend > 0) m_pend--;
        end
        if (m_win > 0) m_win--;
        if (m_dll > 0) m_dll--;
        if (m_sr && m_srcnt < 65535) m_srcnt++;
        m_cmd = 1;
        if (iss) begin
            if (wref) begin m_cmd = 2; m_win = at_least1(int'(rfc)); end
            else if (wzq) begin
                m_cmd = m_zql ? 16 : 32;
                m_win = at_least1(m_zql ? int'(zqcl) : int'(zqcs));
                m_zqp = 0;
            end
            else if (wsre) begin m_cmd = 4; m_sr = 1; m_srcnt = 0; end
            else begin m_cmd = 8; m_sr = 0; m_win = at_least1(int'(xs)); m_dll = at_least1(int'(dllk)); end
        end
        if (z) begin m_zqp = 1; m_zql = int'(zl); end
        nedge++;
        @(posedge clk); #2;
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 190000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc_n);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int sre_at, srx_at, n, refs, seen;
        int order[3];
        bit s_lvl, h_lvl, starve;
        void'($urandom(32'd20240611));

        // R2: credit interval, normal and hot
        do_reset();
        repeat (60) step(0, 0, 0, 0, 0);
        check("R2 pend after 60 edges at interval 30", int'(pend), 2);
        do_reset();
        repeat (45) step(0, 0, 0, 0, 1);
        check("R2 pend after 45 edges hot (interval 15)", int'(pend), 3);

        // R3 / R7: deep postponement then drain
        do_reset();
        repeat (240) step(0, 0, 0, 0, 0);
        check("R3 pend at 8 owed", int'(pend), 8);
        check("R3 urgent low at 8 owed", int'(urgent), 0);
        repeat (30) step(0, 0, 0, 0, 0);
        check("R3 urgent high at 9 owed", int'(urgent), 1);
        refs = 0;
        for (int i = 0; i < 400 && pend != 0; i++) begin
            step(1, 0, i == 3, 0, 0);
            if (cmd[1]) refs++;
        end
        check("R7 all owed refreshes issued", refs, nedge / 30);

        // R11: latched calibration, long then short
        do_reset();
        step(1, 0, 1, 1, 0);
        seen = 1;
        for (int i = 0; i < 6 && seen == 1; i++) begin step(1, 0, 0, 0, 0); seen = int'(cmd); end
        check("R11 long calibration served as ZQCL", seen, 16);
        n = 0;
        while (busy && n < 100) begin n++; step(1, 0, 0, 0, 0); end
        check("R6 ZQCL busy length", n, 20);
        step(1, 0, 1, 0, 0);
        seen = 1;
        for (int i = 0; i < 6 && seen == 1; i++) begin step(1, 0, 0, 0, 0); seen = int'(cmd); end
        check("R11 short calibration served as ZQCS", seen, 32);

        // R9 / R10: self-refresh residency and DLL relock
        do_reset();
        sre_at = -1; srx_at = -1;
        for (int i = 0; i < 60 && srx_at < 0; i++) begin
            step(1, sre_at < 0, 0, 0, 0);
            if (cmd[2]) sre_at = i;
            if (cmd[3]) srx_at = i;
        end
        check("R9 SRE to SRX spacing", srx_at - sre_at, int'(srmin) + 1);
        n = 0;
        while (!dll_rdy && n < 100) begin n++; step(1, 0, 0, 0, 0); end
        check("R10 DLL wait after SRX", n, int'(dllk));

        // R5: priority REF > ZQ > SRE
        do_reset();
        for (int i = 0; i < 30; i++) step(0, 1, i == 0, 0, 0);
        n = 0;
        for (int i = 0; i < 40 && n < 3; i++) begin
            step(1, 1, 0, 0, 0);
            if (!cmd[0]) begin order[n] = int'(cmd); n++; end
        end
        check("R5 first is REF", order[0], 2);
        check("R5 second is ZQCS", order[1], 32);
        check("R5 third is SRE", order[2], 4);
        check("R8 in self-refresh after SRE", int'(in_sr), 1);
        repeat (50) step(1, 1, 0, 0, 0);
        check("R8 no credit in self-refresh", int'(pend), 0);

        // random phases
        for (int ph = 0; ph < 3; ph++) begin
            refi  = CW'(8 + $urandom % 50);
            rfc   = CW'($urandom % 10);
            xs    = CW'($urandom % 12);
            dllk  = CW'($urandom % 20);
            srmin = CW'($urandom % 10);
            zqcl  = CW'(1 + $urandom % 30);
            zqcs  = CW'($urandom % 8);
            do_reset();
            s_lvl = 0; h_lvl = 0; starve = 0;
            for (int i = 0; i < 6000; i++) begin
                if ($urandom % 200 == 0) s_lvl = ~s_lvl;
                if ($urandom % 1500 == 0) h_lvl = ~h_lvl;
                if ($urandom % 300 == 0) starve = ~starve;
                step(starve ? ($urandom % 20 == 0) : ($urandom % 10 < 7),
                     s_lvl, ($urandom % 150 == 0), $urandom % 2, h_lvl);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule